// File: doc/BRIEF.md
# Programmable Filter Clock Configurator

This block sets up an external switched-capacitor band-pass filter, whose centre frequency is a fixed fraction of its input clock. The user picks one of a small set of target centre frequencies by index. The block drives a 5-bit frequency code and a 7-bit Q code on static pins. It also produces a square-wave filter clock whose rate is the target centre frequency times (frequency code + 13). The clock is derived from a 50 MHz system clock.

Every divider value is computed when the design is elaborated, from the base frequency, the step, the code base and the system clock rate. A change of selection waits for the end of the half-period in progress, so the filter never sees a shortened clock level. A one-cycle pulse reports when a full clock period has run at the new setting.

Top module: `filter_clk_cfg`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `filt_clk` is low, `config_done` is low and `f_code` holds the code of entry `RESET_IDX`.
- R2: Table entry i has target centre frequency f0 = `F0_BASE_HZ` + i·`F0_STEP_HZ`, frequency code N = (`N_BASE` + i) mod 32, and half-period H = round(`CLK_HZ` / (2·f0·(N+13))) system clock cycles. After entry i has taken effect, `f_code` equals its N.
- R3: `filt_clk` is a 50% duty square wave. Every high level and every low level lasts exactly H cycles of the entry whose code is on `f_code` when that level begins.
- R4: `f_code` is 5 bits wide (bit 0 is the least significant bit of N). `q_code` always drives the 7-bit value `Q_CODE`, which sets the filter's Q to 64/(128 − `Q_CODE`).
- R5: A selection takes effect only at the clock edge that ends the current half-period. `f_code` changes only at an edge where `filt_clk` also toggles, and no level is ever shorter than a full half-period.
- R6: A selection with `sel_idx` ≥ `NUM_SEL` is ignored. `f_code`, the clock period and `config_done` are unaffected.
- R7: When several in-range selections arrive within one half-period, only the last one is applied. The ones before it never appear on `f_code`.
- R8: `config_done` is high for exactly one cycle: the cycle in which `filt_clk` makes its second toggle after the toggle that applied a new setting. If another setting is applied before that toggle, the pulse for the earlier setting is dropped and counting starts over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Selection strobe, one cycle per request |
| sel_idx | input | IDX_W | Requested table index |
| filt_clk | output | 1 | Square-wave clock to the filter |
| f_code | output | 5 | Static frequency code N |
| q_code | output | 7 | Static Q code |
| config_done | output | 1 | One-cycle pulse after the first full period at a new setting |

## Verification
The bench uses the default build: eight entries, a 4-bit index and a code base of 19. Half-periods then run from 20 to 31 cycles, and the eight frequency codes are all different, so the code on `f_code` tells which entry is active. With these values every entry can be visited in turn, and all eight out-of-range indices (8 to 15) can be tried. Every clock level of the run is timed against the half-period computed for the code in force, so each switch is checked at the phase where it happens to land.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   localparam int unsigned FCODE_W   = 5;
   localparam int unsigned QCODE_W   = 7;
   localparam int unsigned RATIO_OFS = 13;

   function automatic logic [FCODE_W-1:0] fcode_of(input int unsigned idx,
                                                   input int unsigned nbase);
      return FCODE_W'((nbase + idx) % (1 << FCODE_W));
   endfunction

   function automatic int unsigned half_of(input int unsigned idx,
                                           input int unsigned clk_hz,
                                           input int unsigned f0_base,
                                           input int unsigned f0_step,
                                           input int unsigned nbase);
      longint unsigned f0;
      longint unsigned ratio;
      longint unsigned den;
      f0    = longint'(f0_base) + longint'(idx) * longint'(f0_step);
      ratio = longint'(fcode_of(idx, nbase)) + RATIO_OFS;
      den   = 2 * f0 * ratio;
      return int'((longint'(clk_hz) + den / 2) / den);
   endfunction

   function automatic int unsigned max_half(input int unsigned num,
                                            input int unsigned clk_hz,
                                            input int unsigned f0_base,
                                            input int unsigned f0_step,
                                            input int unsigned nbase);
      int unsigned m;
      m = 1;
      for (int unsigned i = 0; i < num; i++) begin
         if (half_of(i, clk_hz, f0_base, f0_step, nbase) > m)
            m = half_of(i, clk_hz, f0_base, f0_step, nbase);
      end
      return m;
   endfunction

endpackage

// File: rtl/pfc_table.sv
module pfc_table #(
   parameter int unsigned NUM_SEL    = 8,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned HALF_W     = 6,
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned F0_BASE_HZ = 25_000,
   parameter int unsigned F0_STEP_HZ = 1_000,
   parameter int unsigned N_BASE     = 19
) (
   input  logic [IDX_W-1:0]                rd_idx,
   output logic [pfc_pkg::FCODE_W-1:0]     rd_n,
   output logic [HALF_W-1:0]               rd_half
);
   import pfc_pkg::*;

   logic [FCODE_W-1:0] n_tab [NUM_SEL];
   logic [HALF_W-1:0]  h_tab [NUM_SEL];

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_ent
      localparam int unsigned HV = half_of(g, CLK_HZ, F0_BASE_HZ, F0_STEP_HZ, N_BASE);
      if (HV < 1) begin : g_bad
         $error("pfc_table: entry %0d has a zero half-period", g);
      end
      assign n_tab[g] = fcode_of(g, N_BASE);
      assign h_tab[g] = HALF_W'(HV);
   end

   always_comb begin
      rd_n    = '0;
      rd_half = '0;
      for (int unsigned k = 0; k < NUM_SEL; k++) begin
         if (rd_idx == IDX_W'(k)) begin
            rd_n    = n_tab[k];
            rd_half = h_tab[k];
         end
      end
   end

endmodule

// File: rtl/pfc_sel_latch.sv
module pfc_sel_latch #(
   parameter int unsigned NUM_SEL = 8,
   parameter int unsigned IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_valid,
   input  logic [IDX_W-1:0] sel_idx,
   input  logic             take,
   output logic             pend,
   output logic [IDX_W-1:0] pend_idx
);
   logic in_range;

   assign in_range = ({1'b0, sel_idx} < (IDX_W+1)'(NUM_SEL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         pend_idx <= '0;
      end else begin
         if (take)
            pend <= 1'b0;
         if (sel_valid && in_range) begin
            pend     <= 1'b1;
            pend_idx <= sel_idx;
         end
      end
   end

endmodule

// File: rtl/pfc_sqwave.sv
module pfc_sqwave #(
   parameter int unsigned HALF_W   = 6,
   parameter int unsigned RST_HALF = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HALF_W-1:0] load_half,
   output logic              filt_clk,
   output logic              boundary
);
   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] half_q;

   assign boundary = (cnt_q == half_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         half_q   <= HALF_W'(RST_HALF);
         filt_clk <= 1'b0;
      end else if (boundary) begin
         cnt_q    <= '0;
         filt_clk <= ~filt_clk;
         if (load)
            half_q <= load_half;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pfc_done_trk.sv
module pfc_done_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic boundary,
   input  logic applied,
   output logic done
);
   logic track_q;
   logic mid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         track_q <= 1'b0;
         mid_q   <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (boundary) begin
            if (applied) begin
               track_q <= 1'b1;
               mid_q   <= 1'b0;
            end else if (track_q) begin
               if (!mid_q) begin
                  mid_q <= 1'b1;
               end else begin
                  done    <= 1'b1;
                  track_q <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/filter_clk_cfg.sv
module filter_clk_cfg #(
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned NUM_SEL    = 8,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned F0_BASE_HZ = 25_000,
   parameter int unsigned F0_STEP_HZ = 1_000,
   parameter int unsigned N_BASE     = 19,
   parameter logic [6:0]  Q_CODE     = 7'd64,
   parameter int unsigned RESET_IDX  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_valid,
   input  logic [IDX_W-1:0] sel_idx,
   output logic             filt_clk,
   output logic [4:0]       f_code,
   output logic [6:0]       q_code,
   output logic             config_done
);
   import pfc_pkg::*;

   localparam int unsigned HALF_MAX = max_half(NUM_SEL, CLK_HZ, F0_BASE_HZ, F0_STEP_HZ, N_BASE);
   localparam int unsigned HALF_W   = $clog2(HALF_MAX + 1);
   localparam int unsigned RST_HALF = half_of(RESET_IDX, CLK_HZ, F0_BASE_HZ, F0_STEP_HZ, N_BASE);
   localparam logic [FCODE_W-1:0] RST_CODE = fcode_of(RESET_IDX, N_BASE);

   if (NUM_SEL < 1 || NUM_SEL > (1 << IDX_W)) begin : g_chk_num
      $error("filter_clk_cfg: NUM_SEL does not fit the index width");
   end
   if (RESET_IDX >= NUM_SEL) begin : g_chk_rst
      $error("filter_clk_cfg: RESET_IDX out of table range");
   end
   if (F0_BASE_HZ == 0) begin : g_chk_f0
      $error("filter_clk_cfg: zero base frequency");
   end

   logic               pend;
   logic [IDX_W-1:0]   pend_idx;
   logic [FCODE_W-1:0] tab_n;
   logic [HALF_W-1:0]  tab_half;
   logic               boundary;
   logic               apply;

   assign apply  = boundary & pend;
   assign q_code = Q_CODE;

   pfc_sel_latch #(.NUM_SEL(NUM_SEL), .IDX_W(IDX_W)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_valid(sel_valid),
      .sel_idx  (sel_idx),
      .take     (apply),
      .pend     (pend),
      .pend_idx (pend_idx)
   );

   pfc_table #(
      .NUM_SEL   (NUM_SEL),
      .IDX_W     (IDX_W),
      .HALF_W    (HALF_W),
      .CLK_HZ    (CLK_HZ),
      .F0_BASE_HZ(F0_BASE_HZ),
      .F0_STEP_HZ(F0_STEP_HZ),
      .N_BASE    (N_BASE)
   ) u_tab (
      .rd_idx (pend_idx),
      .rd_n   (tab_n),
      .rd_half(tab_half)
   );

   pfc_sqwave #(.HALF_W(HALF_W), .RST_HALF(RST_HALF)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (apply),
      .load_half(tab_half),
      .filt_clk (filt_clk),
      .boundary (boundary)
   );

   pfc_done_trk u_done (
      .clk     (clk),
      .rst_n   (rst_n),
      .boundary(boundary),
      .applied (apply),
      .done    (config_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         f_code <= RST_CODE;
      else if (apply)
         f_code <= tab_n;
   end

endmodule

// File: rtl/pfc_chk.sv
module pfc_chk #(
   parameter int unsigned HALF_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              filt_clk,
   input logic [4:0]        f_code,
   input logic              config_done,
   input logic [HALF_W-1:0] cnt,
   input logic [HALF_W-1:0] half_act
);

   assert_code_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (f_code != $past(f_code)) |-> (filt_clk != $past(filt_clk)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      config_done |=> !config_done);

   assert_done_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      config_done |-> (filt_clk != $past(filt_clk)));

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < half_act);

endmodule

bind filter_clk_cfg pfc_chk #(.HALF_W(HALF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .filt_clk   (filt_clk),
   .f_code     (f_code),
   .config_done(config_done),
   .cnt        (u_wave.cnt_q),
   .half_act   (u_wave.half_q)
);

// File: tb/tb_filter_clk_cfg.sv
module tb_filter_clk_cfg;
   localparam int NUM = 8;
   localparam int IW  = 4;

   int total = 0;
   int bad   = 0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_valid = 1'b0;
   logic [IW-1:0] sel_idx = '0;
   logic          filt_clk;
   logic [4:0]    f_code;
   logic [6:0]    q_code;
   logic          config_done;

   always #10 clk = ~clk;

   filter_clk_cfg dut (
      .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_idx(sel_idx),
      .filt_clk(filt_clk), .f_code(f_code), .q_code(q_code), .config_done(config_done)
   );

   function automatic int b_n(input int i);
      return (19 + i) % 32;
   endfunction

   function automatic int b_half(input int i);
      longint den;
      den = 2 * longint'(25000 + 1000 * i) * longint'(b_n(i) + 13);
      return int'((longint'(50_000_000) + den / 2) / den);
   endfunction

   function automatic int b_idx(input logic [4:0] c);
      return (int'(c) + 32 - 19) % 32;
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   bit         mon_on = 1'b0;
   logic       pf;
   logic [4:0] pc;
   logic [4:0] run_code;
   int         run_len;
   int         tog = 3;
   int         done_cnt = 0;
   int         code_chg = 0;

   always @(negedge clk) begin
      logic t;
      logic c;
      if (mon_on) begin
         t = (filt_clk != pf);
         c = (f_code != pc);
         if (t) begin
            chk(run_len == b_half(b_idx(run_code)), "R3 level length", run_len,
                b_half(b_idx(run_code)));
            if (c) tog = 0;
            else if (tog < 3) tog++;
            run_len  = 1;
            run_code = f_code;
         end else begin
            run_len++;
            if (c) chk(1'b0, "R5 code change without clock edge", int'(f_code), int'(pc));
         end
         if (c) code_chg++;
         chk(config_done == (t && !c && tog == 2), "R8 done pulse timing",
             int'(config_done), int'(t && !c && tog == 2));
         if (config_done) done_cnt++;
         pf = filt_clk;
         pc = f_code;
      end
   end

   task automatic pick(input int idx);
      @(negedge clk);
      sel_valid = 1'b1;
      sel_idx   = IW'(idx);
      @(negedge clk);
      sel_valid = 1'b0;
   endtask

   task automatic wait_done(input string rq);
      int n;
      int d0;
      n  = 0;
      d0 = done_cnt;
      while (done_cnt == d0 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(done_cnt != d0, rq, done_cnt - d0, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs during reset
      chk(filt_clk == 1'b0, "R1 clock low in reset", int'(filt_clk), 0);
      chk(f_code == 5'(b_n(0)), "R1 code in reset", int'(f_code), b_n(0));
      #1 rst_n = 1'b1;
      pf = filt_clk; pc = f_code; run_code = f_code; run_len = 1; tog = 3;
      mon_on = 1'b1;
      chk(config_done == 1'b0, "R1 done low after reset", int'(config_done), 0);
      chk(f_code == 5'(b_n(0)), "R1 reset code", int'(f_code), b_n(0));
      // R4: static Q code
      chk(q_code == 7'd64, "R4 q code", int'(q_code), 64);

      // R2/R3/R5/R8: visit every entry, selecting at varied phases
      for (int k = 0; k < NUM; k++) begin
         int idx;
         idx = (k + 1) % NUM;
         pick(idx);
         wait_done("R8 done after switch");
         chk(f_code == 5'(b_n(idx)), "R2 code of entry", int'(f_code), b_n(idx));
         repeat (3 * k + 1) @(negedge clk);
      end
      chk(q_code == 7'd64, "R4 q code after sweep", int'(q_code), 64);

      // R6: out-of-range selections are ignored
      begin
         logic [4:0] c0;
         int d0;
         int cc0;
         c0 = f_code; d0 = done_cnt; cc0 = code_chg;
         for (int j = NUM; j < (1 << IW); j++) pick(j);
         repeat (200) @(negedge clk);
         chk(f_code == c0, "R6 code unchanged", int'(f_code), int'(c0));
         chk(code_chg == cc0, "R6 no code change", code_chg - cc0, 0);
         chk(done_cnt == d0, "R6 no done pulse", done_cnt - d0, 0);
      end

      // R7: two selections within one half-period, last wins
      begin
         logic p;
         int cc0;
         p = filt_clk;
         while (filt_clk == p) @(negedge clk);
         cc0 = code_chg;
         sel_valid = 1'b1;
         sel_idx   = IW'(3);
         @(negedge clk);
         sel_idx   = IW'(5);
         @(negedge clk);
         sel_valid = 1'b0;
         wait_done("R7 done after double pick");
         chk(code_chg - cc0 == 1, "R7 single code change", code_chg - cc0, 1);
         chk(f_code == 5'(b_n(5)), "R7 last pick applied", int'(f_code), b_n(5));
         repeat (150) @(negedge clk);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule